// File: doc/BRIEF.md
# Prescaled Interval Timer Channel

This block is a single 16-bit timer channel. Its count advances on a tick that comes either from every clock or from a power-of-two divider. It counts up or down, and it wraps either at a programmable limit or at the full 16-bit range. Three comparators watch the count and raise a one-cycle strobe when it lands on their value. A wrap raises a strobe whose type depends on the mode.

All configuration arrives as static input fields. A separate one-cycle clear input zeroes the count. The outputs are the registered count and five event strobes. Each strobe is high in the same cycle that the count output first shows the value that caused it. Interrupt latching and any register access belong to the logic around the block.

Top module: `ptmr_channel`

## Requirements
- R1: With `clk_ctrl[0]` set and `clk_ctrl[4:1]` = N, the count moves once every 2^(N+1) clocks. With `clk_ctrl[0]` clear, it moves on every clock.
- R2: While `cnt_ctrl[0]` (halt) is set, the count keeps its value and no strobe fires.
- R3: When `cnt_ctrl[2]` is clear, the count increments. With `cnt_ctrl[1]` set, it runs 0..`limit` and then returns to 0. With `cnt_ctrl[1]` clear, it runs 0..0xFFFF and then returns to 0.
- R4: When `cnt_ctrl[2]` is set, the count decrements. From 0 it reloads the top of its range: `limit` in interval mode, 0xFFFF otherwise.
- R5: A wrap pulses `intv_evt` for one cycle when `cnt_ctrl[1]` is set, and pulses `ovf_evt` when it is clear. Never both.
- R6: With `cnt_ctrl[3]` set, `match_evt[i]` pulses for one cycle when a count step lands on `match_val[i]`. The three comparators are independent.
- R7: In interval mode, a comparator whose value is greater than `limit` never pulses.
- R8: With `cnt_ctrl[3]` clear, no match strobe fires.
- R9: A cycle with `cnt_clear` high loads 0 into the count, even while halted. It fires no strobe and restarts the divider.
- R10: Any change of `clk_ctrl` restarts the divider, so the next prescaled tick comes a full 2^(N+1) clocks after the change.
- R11: If a wrap and a match happen on the same step, both strobes fire in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_ctrl | input | 5 | Bit 0: divider enable. Bits 4:1: divider exponent N |
| cnt_ctrl | input | 4 | Bit 0: halt. Bit 1: interval mode. Bit 2: count down. Bit 3: match enable |
| cnt_clear | input | 1 | One-cycle strobe that zeroes the count |
| limit | input | 16 | Top of the range in interval mode |
| match_val | input | 3x16 | Comparator values; entry i drives `match_evt[i]` |
| count | output | 16 | Current count |
| intv_evt | output | 1 | Wrap strobe in interval mode |
| ovf_evt | output | 1 | Wrap strobe in full-range mode |
| match_evt | output | 3 | Per-comparator match strobes |

## Verification
The following are checked on every cycle:
- the count holds while halted;
- clear leaves a zero count with no strobe;
- each wrap strobe agrees with the mode of the step before it;
- an upward wrap lands on 0 and a downward wrap lands on the top of the range;
- a match strobe shows its own comparator value and never fires when disabled or above the limit;
- with the divider on, no two consecutive cycles both step.

Only the bench scenarios can show the following, against a cycle model of the requirements:
- exact divider periods, and the restart after a configuration change;
- the full 65536-step overflow;
- coinciding wrap and match strobes;
- the number of pulses over a window.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int CNT_W   = 16;
    localparam int PS_W    = 4;
    localparam int N_MATCH = 3;

    // clock-control field: bit 0 enable, bits 4:1 exponent
    typedef struct packed {
        logic [PS_W-1:0] ratio;
        logic            enable;
    } clk_cfg_t;

    // counter-control field: bit 0 halt ... bit 3 match enable
    typedef struct packed {
        logic match_en;
        logic down;
        logic interval;
        logic halt;
    } cnt_cfg_t;

    typedef struct packed {
        logic intv;
        logic ovf;
    } wrap_evt_t;

    function automatic logic [CNT_W-1:0] range_top(input logic interval,
                                                   input logic [CNT_W-1:0] lim);
        return interval ? lim : {CNT_W{1'b1}};
    endfunction

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
    import ptmr_pkg::*;
#(
    parameter int RATIO_W = PS_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_enable,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic               restart_req,
    output logic               tick
);
    localparam int DIV_W = 2 ** RATIO_W;

    logic [DIV_W-1:0]   div_q;
    logic [RATIO_W:0]   cfg_q;
    logic [DIV_W-1:0]   div_last;
    logic               restart;

    // 2^(ratio+1)-1 as a right-shifted all-ones vector
    assign div_last = {DIV_W{1'b1}} >> (DIV_W - 1 - int'(cfg_ratio));
    assign restart  = restart_req || ({cfg_ratio, cfg_enable} != cfg_q);

    always_comb begin
        if (!cfg_enable)
            tick = 1'b1;
        else if (restart)
            tick = 1'b0;
        else
            tick = (div_q == div_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cfg_q <= '0;
        end else begin
            cfg_q <= {cfg_ratio, cfg_enable};
            if (restart || tick)
                div_q <= '0;
            else
                div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter
    import ptmr_pkg::*;
#(
    parameter int WIDTH = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clear,
    input  cnt_cfg_t         cfg,
    input  logic [WIDTH-1:0] limit,
    output logic [WIDTH-1:0] count,
    output wrap_evt_t        wrap_evt,
    output logic             step,
    output logic [WIDTH-1:0] cnt_next,
    output logic [WIDTH-1:0] top
);
    logic at_end;

    assign top  = range_top(cfg.interval, limit);
    assign step = tick && !cfg.halt && !clear;

    always_comb begin
        if (cfg.down) begin
            at_end   = (count == '0);
            cnt_next = at_end ? top : count - 1'b1;
        end else begin
            at_end   = (count >= top);
            cnt_next = at_end ? '0 : count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count    <= '0;
            wrap_evt <= '0;
        end else if (step) begin
            count         <= cnt_next;
            wrap_evt.intv <= at_end && cfg.interval;
            wrap_evt.ovf  <= at_end && !cfg.interval;
        end else begin
            wrap_evt <= '0;
        end
    end
endmodule

// File: rtl/ptmr_match.sv
module ptmr_match
    import ptmr_pkg::*;
#(
    parameter int WIDTH = CNT_W,
    parameter int NUM   = N_MATCH
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      step,
    input  logic                      enable,
    input  logic                      interval,
    input  logic [WIDTH-1:0]          cnt_next,
    input  logic [WIDTH-1:0]          top,
    input  logic [NUM-1:0][WIDTH-1:0] match_val,
    output logic [NUM-1:0]            hit
);
    for (genvar g = 0; g < NUM; g++) begin : g_cmp
        logic reachable;
        assign reachable = !interval || (match_val[g] <= top);

        always_ff @(posedge clk) begin
            if (rst)
                hit[g] <= 1'b0;
            else
                hit[g] <= step && enable && reachable && (cnt_next == match_val[g]);
        end
    end
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
    import ptmr_pkg::*;
#(
    parameter int WIDTH   = CNT_W,
    parameter int RATIO_W = PS_W,
    parameter int NUM     = N_MATCH
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [RATIO_W:0]          clk_ctrl,
    input  logic [3:0]                cnt_ctrl,
    input  logic                      cnt_clear,
    input  logic [WIDTH-1:0]          limit,
    input  logic [NUM-1:0][WIDTH-1:0] match_val,
    output logic [WIDTH-1:0]          count,
    output logic                      intv_evt,
    output logic                      ovf_evt,
    output logic [NUM-1:0]            match_evt
);
    cnt_cfg_t         ccfg;
    wrap_evt_t        wevt;
    logic             tick;
    logic             step;
    logic [WIDTH-1:0] cnt_next;
    logic [WIDTH-1:0] top;

    assign ccfg = cnt_cfg_t'(cnt_ctrl);

    ptmr_prescaler #(.RATIO_W(RATIO_W)) u_ps (
        .clk         (clk),
        .rst         (rst),
        .cfg_enable  (clk_ctrl[0]),
        .cfg_ratio   (clk_ctrl[RATIO_W:1]),
        .restart_req (cnt_clear),
        .tick        (tick)
    );

    ptmr_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .clear    (cnt_clear),
        .cfg      (ccfg),
        .limit    (limit),
        .count    (count),
        .wrap_evt (wevt),
        .step     (step),
        .cnt_next (cnt_next),
        .top      (top)
    );

    ptmr_match #(.WIDTH(WIDTH), .NUM(NUM)) u_match (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .enable    (ccfg.match_en),
        .interval  (ccfg.interval),
        .cnt_next  (cnt_next),
        .top       (top),
        .match_val (match_val),
        .hit       (match_evt)
    );

    assign intv_evt = wevt.intv;
    assign ovf_evt  = wevt.ovf;
endmodule

// File: rtl/ptmr_channel_chk.sv
module ptmr_channel_chk #(
    parameter int WIDTH   = 16,
    parameter int RATIO_W = 4,
    parameter int NUM     = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic [RATIO_W:0]          clk_ctrl,
    input logic [3:0]                cnt_ctrl,
    input logic                      cnt_clear,
    input logic [WIDTH-1:0]          limit,
    input logic [NUM-1:0][WIDTH-1:0] match_val,
    input logic [WIDTH-1:0]          count,
    input logic                      intv_evt,
    input logic                      ovf_evt,
    input logic [NUM-1:0]            match_evt
);
    AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (rst)
        (clk_ctrl[0] && $stable(clk_ctrl) && !cnt_clear && count != $past(count))
        |=> (count == $past(count))); // R1

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!cnt_clear && cnt_ctrl[0]) |=> (count == $past(count) && !intv_evt && !ovf_evt)); // R2

    AST_UP_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((intv_evt || ovf_evt) && !$past(cnt_ctrl[2])) |-> (count == '0)); // R3

    AST_DOWN_WRAP_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (intv_evt && $past(cnt_ctrl[2])) |-> (count == $past(limit))); // R4

    AST_DOWN_WRAP_FULL: assert property (@(posedge clk) disable iff (rst)
        (ovf_evt && $past(cnt_ctrl[2])) |-> (count == {WIDTH{1'b1}})); // R4

    AST_INTV_IN_MODE: assert property (@(posedge clk) disable iff (rst)
        intv_evt |-> $past(cnt_ctrl[1])); // R5

    AST_OVF_IN_MODE: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |-> !$past(cnt_ctrl[1])); // R5

    AST_MATCH_OFF: assert property (@(posedge clk) disable iff (rst)
        !cnt_ctrl[3] |=> (match_evt == '0)); // R8

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        cnt_clear |=> (count == '0 && !intv_evt && !ovf_evt && match_evt == '0)); // R9

    for (genvar g = 0; g < NUM; g++) begin : g_m
        AST_MATCH_VALUE: assert property (@(posedge clk) disable iff (rst)
            match_evt[g] |-> (count == $past(match_val[g]))); // R6

        AST_MATCH_ABOVE_LIMIT: assert property (@(posedge clk) disable iff (rst)
            match_evt[g] |-> (!$past(cnt_ctrl[1]) || $past(match_val[g] <= limit))); // R7
    end
endmodule

bind ptmr_channel ptmr_channel_chk #(.WIDTH(WIDTH), .RATIO_W(RATIO_W), .NUM(NUM)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_ctrl  (clk_ctrl),
    .cnt_ctrl  (cnt_ctrl),
    .cnt_clear (cnt_clear),
    .limit     (limit),
    .match_val (match_val),
    .count     (count),
    .intv_evt  (intv_evt),
    .ovf_evt   (ovf_evt),
    .match_evt (match_evt)
);

// File: tb/test_ptmr_channel.sv
module test_ptmr_channel;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [4:0]       clk_ctrl = '0;
    logic [3:0]       cnt_ctrl = 4'b0001;
    logic             cnt_clear = 1'b0;
    logic [15:0]      limit = '0;
    logic [2:0][15:0] match_val = '0;
    logic [15:0]      count;
    logic             intv_evt, ovf_evt;
    logic [2:0]       match_evt;

    int n_checks = 0;
    int n_fail = 0;
    string cur_tag = "R9";
    int p_intv = 0, p_ovf = 0;
    int p_m[3] = '{0, 0, 0};

    typedef struct {
        logic [15:0] cnt;
        logic        iv;
        logic        ov;
        logic [2:0]  m;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk; // 125 MHz

    ptmr_channel i_ptmr_channel (
        .clk(clk), .rst(rst), .clk_ctrl(clk_ctrl), .cnt_ctrl(cnt_ctrl),
        .cnt_clear(cnt_clear), .limit(limit), .match_val(match_val),
        .count(count), .intv_evt(intv_evt), .ovf_evt(ovf_evt), .match_evt(match_evt)
    );

    // Reference built from the requirements: pushes one expected item per edge.
    logic [15:0] m_cnt = '0;
    int          m_div = 0;
    logic [4:0]  m_cfg = '0;
    always @(posedge clk) begin
        exp_t e;
        bit restart, tk, wrap, stp;
        logic [15:0] top, nxt;
        e.tag = cur_tag; e.iv = 0; e.ov = 0; e.m = '0;
        if (rst) begin
            m_cnt = '0; m_div = 0; m_cfg = '0;
        end else begin
            restart = (clk_ctrl != m_cfg) || cnt_clear;
            if (!clk_ctrl[0]) tk = 1;
            else if (restart) tk = 0;
            else tk = ((m_div + 1) == (1 << (int'(clk_ctrl[4:1]) + 1)));
            m_div = (restart || tk) ? 0 : m_div + 1;
            m_cfg = clk_ctrl;
            top = cnt_ctrl[1] ? limit : 16'hFFFF;
            stp = tk && !cnt_ctrl[0] && !cnt_clear;
            if (cnt_ctrl[2]) begin
                wrap = (m_cnt == 0);
                nxt  = wrap ? top : m_cnt - 16'd1;
            end else begin
                wrap = (m_cnt >= top);
                nxt  = wrap ? 16'd0 : m_cnt + 16'd1;
            end
            if (cnt_clear) m_cnt = '0;
            else if (stp) begin
                m_cnt = nxt;
                e.iv = wrap && cnt_ctrl[1];
                e.ov = wrap && !cnt_ctrl[1];
                for (int i = 0; i < 3; i++)
                    e.m[i] = cnt_ctrl[3] && (nxt == match_val[i]) &&
                             (!cnt_ctrl[1] || match_val[i] <= limit);
            end
        end
        e.cnt = m_cnt;
        sb_q.push_back(e);
    end

    // Monitor: compares design outputs away from the active edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (count !== e.cnt || intv_evt !== e.iv || ovf_evt !== e.ov || match_evt !== e.m) begin
                n_fail++;
                $display("FAIL %s: count/intv/ovf/match actual %h/%b/%b/%b expected %h/%b/%b/%b",
                         e.tag, count, intv_evt, ovf_evt, match_evt, e.cnt, e.iv, e.ov, e.m);
            end
        end
        if (!rst) begin
            p_intv += int'(intv_evt);
            p_ovf  += int'(ovf_evt);
            for (int i = 0; i < 3; i++) p_m[i] += int'(match_evt[i]);
        end
    end

    task automatic run(input string tag, input int n);
        cur_tag = tag;
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_pulse(input string tag);
        cur_tag = tag;
        cnt_clear = 1'b1;
        @(negedge clk);
        cnt_clear = 1'b0;
    endtask

    task automatic zero_pulses();
        p_intv = 0; p_ovf = 0;
        for (int i = 0; i < 3; i++) p_m[i] = 0;
    endtask

    task automatic check_int(input string tag, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                run("R9", 3);
                rst = 1'b0;
                // R3: full-range upward count, every clock
                cnt_ctrl = 4'b0000;
                run("R3", 20);
                clear_pulse("R9");
                // R5: full-range overflow after 65536 steps
                zero_pulses();
                run("R5", 65536);
                #1 check_int("R5 ovf pulses", p_ovf, 1);
                @(negedge clk);
                // R6 R7 R11: interval mode, limit 9, matches 3, 0 (with wrap), 12 (above limit)
                limit = 16'd9;
                match_val[0] = 16'd3; match_val[1] = 16'd0; match_val[2] = 16'd12;
                cnt_ctrl = 4'b1010;
                clear_pulse("R9");
                zero_pulses();
                run("R11", 30);
                #1;
                check_int("R3 interval wraps", p_intv, 3);
                check_int("R6 match0 pulses", p_m[0], 3);
                check_int("R11 match1 with wrap", p_m[1], 3);
                check_int("R7 match above limit", p_m[2], 0);
                @(negedge clk);
                // R8: match enable off
                cnt_ctrl = 4'b0010;
                zero_pulses();
                run("R8", 25);
                #1 check_int("R8 no match pulses", p_m[0] + p_m[1] + p_m[2], 0);
                @(negedge clk);
                // R4: downward interval with match at top
                limit = 16'd5; match_val[0] = 16'd5;
                cnt_ctrl = 4'b1110;
                clear_pulse("R9");
                run("R4", 20);
                // R4 R5: downward full range, 0 -> FFFF overflow
                cnt_ctrl = 4'b0100;
                clear_pulse("R9");
                run("R4", 10);
                // R2: halt
                cnt_ctrl = 4'b0101;
                run("R2", 12);
                // R9: clear wins while halted
                clear_pulse("R9");
                run("R9", 4);
                // R1: divider N=1 (period 4), then N=0 (period 2)
                cnt_ctrl = 4'b0000;
                clk_ctrl = 5'b00011;
                run("R1", 40);
                clk_ctrl = 5'b00001;
                run("R10", 30);
                // R10: change mid period then clear mid period
                clk_ctrl = 5'b00101;
                run("R10", 7);
                clk_ctrl = 5'b00111;
                run("R10", 5);
                clear_pulse("R9");
                run("R1", 40);
                // R1: divider off again
                clk_ctrl = 5'b00110;
                run("R1", 10);
                @(negedge clk);
            end
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule